// File: doc/BRIEF.md
# Three-Lane Simultaneous-Sampling Converter Serial Slave

This block stands in for the serial side of a converter that samples three channel pairs at the same instant. It lets a host controller be built and exercised without the analog part. A host writes a 32-bit control word over a frame-synchronised serial port. It starts a conversion with a strobe and watches a status line that reports the conversion as busy or raises an interrupt when it is done. It then reads the results back on three serial output lanes. Each lane carries the two 16-bit results of its channel pair in one 32-clock frame. The six sample values come in on parallel ports, and the block latches them at the moment a conversion completes.

Every host-facing input is brought into the system clock domain through a synchroniser and then edge-detected. The conversion length is a parameter. Control bit 11 picks the time base: when it is clear, the length is counted in system clock cycles, and when it is set, it is counted in rising edges of the external conversion clock. The samples and the serial lines are plain single-purpose pins with no flow control. The host sets the pace through the frame signal and the serial clock, so no back-pressure rules apply.

Top module: `adcs_top`

## Requirements
- R1: While `rst` is high, the control register is loaded with 0x000003FF and any conversion in progress is abandoned. After `rst` falls, the status line stays inactive until a new conversion-start rising edge arrives.
- R2: A frame runs from a falling edge of `frame_n` to the next rising edge. Bits on `sdin` are taken MSB first, one on each rising `sck`. A frame of exactly 32 bits replaces the whole control register when `frame_n` rises.
- R3: A frame of exactly 8 bits replaces control bits 31:24 only, and bits 23:0 keep their value.
- R4: A frame that ends after any bit count other than 8 or 32 leaves the control register unchanged.
- R5: When control bit 11 is 0, a conversion lasts exactly CONV_LEN system clock cycles. When bit 11 is 1, it lasts CONV_LEN rising edges of `ext_clk`.
- R6: A rising edge on `conv_start` starts a conversion and marks it busy. A rising edge that arrives while a conversion is busy is ignored and does not extend it.
- R7: When a conversion completes, the six sample inputs are latched as the new results, and the next read frame returns those values.
- R8: Lane A on `sdo_a` sends {smp_a0, smp_a1}, lane B on `sdo_b` sends {smp_b0, smp_b1}, and lane C on `sdo_c` sends {smp_c0, smp_c1}, each MSB first. The first bit is driven after `frame_n` falls, and the lane moves to the next bit after each falling `sck`.
- R9: All three `sdo_*` lines are 0 whenever `frame_n` is high.
- R10: When control bit 21 is 0, `status_out` shows busy. Busy is high when bit 20 is 0 and low when bit 20 is 1. When bit 21 is 1, `status_out` is an interrupt that is set when a conversion completes and cleared by the next frame start or conversion start. The interrupt is low when asserted if bit 20 is 0, and high when asserted if bit 20 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion start; a rising edge starts a conversion |
| ext_clk | input | 1 | External conversion time base |
| frame_n | input | 1 | Frame sync, active low |
| sck | input | 1 | Serial clock |
| sdin | input | 1 | Serial control data in |
| smp_a0 | input | 16 | Pair A, first channel sample |
| smp_a1 | input | 16 | Pair A, second channel sample |
| smp_b0 | input | 16 | Pair B, first channel sample |
| smp_b1 | input | 16 | Pair B, second channel sample |
| smp_c0 | input | 16 | Pair C, first channel sample |
| smp_c1 | input | 16 | Pair C, second channel sample |
| status_out | output | 1 | Busy or interrupt line |
| sdo_a | output | 1 | Serial result lane A |
| sdo_b | output | 1 | Serial result lane B |
| sdo_c | output | 1 | Serial result lane C |
| ctrl_reg | output | 32 | Current control register |

## Verification
The bench sends frames of 8, 12, 32 and 33 bits. A design that counted bits wrongly would then corrupt the control register on a stray length or drop a valid byte write. A second conversion start is sent during a conversion. A design that restarted its counter on that edge would stretch the busy time past CONV_LEN cycles. The external time-base test must show a busy time about eight times longer, which exposes a design that keeps counting the system clock. The status tests cover both polarities and the interrupt mode, and a reset during a conversion must leave the status line quiet with no late completion.

// File: rtl/adcs_pkg.sv
`timescale 1ns / 1ps
package adcs_pkg;
  localparam int CTRL_W      = 32;
  localparam int SMP_W       = 16;
  localparam int LANES       = 3;
  localparam int CH_PER_LANE = 2;
  localparam int LANE_W      = SMP_W * CH_PER_LANE;
  localparam int BYTE_W      = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 32'h0000_03FF;
  localparam int B_XCLK   = 11;
  localparam int B_STMODE = 21;
  localparam int B_STPOL  = 20;
endpackage

// File: rtl/adcs_edge_sync.sv
`timescale 1ns / 1ps
module adcs_edge_sync #(
  parameter int               W       = 1,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/adcs_ctrl_port.sv
`timescale 1ns / 1ps
module adcs_ctrl_port
  import adcs_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          in_frame,
  input  logic          bit_strobe,
  input  logic          bit_in,
  output logic [CW-1:0] ctrl
);
  localparam int NW = $clog2(CW + 2);
  localparam logic [NW-1:0] N_FULL = NW'(CW);
  localparam logic [NW-1:0] N_BYTE = NW'(BW);
  localparam logic [NW-1:0] N_MAX  = '1;

  logic [CW-1:0] shreg;
  logic [NW-1:0] nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      nbits <= '0;
    end else if (frame_start) begin
      shreg <= '0;
      nbits <= '0;
    end else if (in_frame && bit_strobe) begin
      shreg <= {shreg[CW-2:0], bit_in};
      if (nbits != N_MAX) nbits <= nbits + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RST;
    end else if (frame_end && in_frame) begin
      if (nbits == N_FULL)      ctrl <= shreg;
      else if (nbits == N_BYTE) ctrl[CW-1 -: BW] <= shreg[BW-1:0];
    end
  end
endmodule

// File: rtl/adcs_conv_engine.sv
`timescale 1ns / 1ps
module adcs_conv_engine #(
  parameter int CONV_LEN = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic use_ext,
  input  logic ext_tick,
  output logic busy,
  output logic done
);
  localparam int CNW = $clog2(CONV_LEN + 1);
  localparam logic [CNW-1:0] LAST = CNW'(CONV_LEN - 1);

  logic [CNW-1:0] cnt;
  logic           tick;

  assign tick = use_ext ? ext_tick : 1'b1;
  assign done = busy && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcs_readout_lane.sv
`timescale 1ns / 1ps
module adcs_readout_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         active,
  input  logic [W-1:0] word,
  output logic         sdo
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= word;
    else if (shift) shreg <= {shreg[W-2:0], 1'b0};
  end

  assign sdo = active & shreg[W-1];
endmodule

// File: rtl/adcs_top.sv
`timescale 1ns / 1ps
module adcs_top
  import adcs_pkg::*;
#(
  parameter int CONV_LEN    = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              ext_clk,
  input  logic              frame_n,
  input  logic              sck,
  input  logic              sdin,
  input  logic [SMP_W-1:0]  smp_a0,
  input  logic [SMP_W-1:0]  smp_a1,
  input  logic [SMP_W-1:0]  smp_b0,
  input  logic [SMP_W-1:0]  smp_b1,
  input  logic [SMP_W-1:0]  smp_c0,
  input  logic [SMP_W-1:0]  smp_c1,
  output logic              status_out,
  output logic              sdo_a,
  output logic              sdo_b,
  output logic              sdo_c,
  output logic [CTRL_W-1:0] ctrl_reg
);
  localparam int NIN   = 5;
  localparam int I_CS  = 0;
  localparam int I_XC  = 1;
  localparam int I_FR  = 2;
  localparam int I_SCK = 3;
  localparam int I_SDI = 4;
  localparam int RES_W = LANES * LANE_W;
  localparam logic [NIN-1:0] SYNC_RST = NIN'(1) << I_FR;

  logic [NIN-1:0] in_lvl, in_rise, in_fall;

  adcs_edge_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   ({sdin, sck, frame_n, ext_clk, conv_start}),
    .level (in_lvl),
    .rise  (in_rise),
    .fall  (in_fall)
  );

  logic frame_start, frame_end, start_rise;
  assign frame_start = in_fall[I_FR];
  assign frame_end   = in_rise[I_FR];
  assign start_rise  = in_rise[I_CS];

  logic unused_edges;
  assign unused_edges = ^{in_lvl[I_CS], in_lvl[I_XC], in_lvl[I_FR], in_lvl[I_SCK],
                          in_fall[I_CS], in_fall[I_XC], in_rise[I_SDI], in_fall[I_SDI]};

  logic frame_active;
  always_ff @(posedge clk) begin
    if (rst)              frame_active <= 1'b0;
    else if (frame_start) frame_active <= 1'b1;
    else if (frame_end)   frame_active <= 1'b0;
  end

  adcs_ctrl_port #(.CW(CTRL_W), .BW(BYTE_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .in_frame    (frame_active),
    .bit_strobe  (in_rise[I_SCK]),
    .bit_in      (in_lvl[I_SDI]),
    .ctrl        (ctrl_reg)
  );

  logic busy_q, conv_done;
  adcs_conv_engine #(.CONV_LEN(CONV_LEN)) u_conv (
    .clk      (clk),
    .rst      (rst),
    .start    (start_rise),
    .use_ext  (ctrl_reg[B_XCLK]),
    .ext_tick (in_rise[I_XC]),
    .busy     (busy_q),
    .done     (conv_done)
  );

  logic [RES_W-1:0] res_flat;
  always_ff @(posedge clk) begin
    if (rst)            res_flat <= '0;
    else if (conv_done) res_flat <= {smp_a0, smp_a1, smp_b0, smp_b1, smp_c0, smp_c1};
  end

  logic int_flag;
  always_ff @(posedge clk) begin
    if (rst)                            int_flag <= 1'b0;
    else if (conv_done)                 int_flag <= 1'b1;
    else if (frame_start || start_rise) int_flag <= 1'b0;
  end

  always_comb begin
    if (ctrl_reg[B_STMODE]) status_out = ctrl_reg[B_STPOL] ? int_flag : ~int_flag;
    else                    status_out = ctrl_reg[B_STPOL] ? ~busy_q : busy_q;
  end

  logic [LANES-1:0] sdo_v;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adcs_readout_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (frame_start),
      .shift  (frame_active && in_fall[I_SCK]),
      .active (frame_active),
      .word   (res_flat[(LANES-1-l)*LANE_W +: LANE_W]),
      .sdo    (sdo_v[l])
    );
  end

  assign sdo_a = sdo_v[0];
  assign sdo_b = sdo_v[1];
  assign sdo_c = sdo_v[2];
endmodule

// File: rtl/adcs_checker.sv
`timescale 1ns / 1ps
module adcs_checker
  import adcs_pkg::*;
#(
  parameter int RES_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] ctrl,
  input logic              busy,
  input logic              conv_rise,
  input logic              frame_end,
  input logic [RES_W-1:0]  res
);
  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl == CTRL_RST) && !busy); // R1

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(ctrl)); // R4

  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(conv_rise)); // R6

  AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(res) && !$past(rst)) |-> $fell(busy)); // R7
endmodule

bind adcs_top adcs_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl      (ctrl_reg),
  .busy      (busy_q),
  .conv_rise (start_rise),
  .frame_end (frame_end),
  .res       (res_flat)
);

// File: tb/adcs_top_bench.sv
`timescale 1ns / 1ps
module adcs_top_bench;
  localparam int LEN = 19;

  logic clk = 0, rst = 1, conv_start = 0, ext_clk = 0, frame_n = 1, sck = 0, sdin = 0;
  logic [15:0] smp_a0 = 0, smp_a1 = 0, smp_b0 = 0, smp_b1 = 0, smp_c0 = 0, smp_c1 = 0;
  logic status_out, sdo_a, sdo_b, sdo_c;
  logic [31:0] ctrl_reg;
  logic ext_en = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always begin
    #20;
    ext_clk = ext_en ? ~ext_clk : 1'b0;
  end

  adcs_top #(.CONV_LEN(LEN)) u_adcs_top (
    .clk(clk), .rst(rst), .conv_start(conv_start), .ext_clk(ext_clk),
    .frame_n(frame_n), .sck(sck), .sdin(sdin),
    .smp_a0(smp_a0), .smp_a1(smp_a1), .smp_b0(smp_b0), .smp_b1(smp_b1),
    .smp_c0(smp_c0), .smp_c1(smp_c1),
    .status_out(status_out), .sdo_a(sdo_a), .sdo_b(sdo_b), .sdo_c(sdo_c),
    .ctrl_reg(ctrl_reg)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_frame(input int n, input logic [63:0] val,
                          output logic [31:0] ca, output logic [31:0] cb, output logic [31:0] cc);
    ca = 0; cb = 0; cc = 0;
    @(negedge clk) frame_n = 0;
    for (int i = 0; i < n; i++) begin
      sdin = val[n-1-i];
      repeat (6) @(negedge clk);
      if (i < 32) begin
        ca[31-i] = sdo_a; cb[31-i] = sdo_b; cc[31-i] = sdo_c;
      end
      sck = 1;
      repeat (6) @(negedge clk);
      sck = 0;
    end
    repeat (6) @(negedge clk);
    frame_n = 1; sdin = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic write_ctrl(input int n, input logic [63:0] val);
    logic [31:0] a, b, c;
    do_frame(n, val, a, b, c);
  endtask

  task automatic pulse_measure(input logic act, input bit retrig, output int cyc);
    cyc = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      conv_start = (k < 4) || (retrig && k >= 8 && k < 12);
      if (status_out == act) cyc++;
    end
    conv_start = 0;
  endtask

  task automatic t_reset;
    check(ctrl_reg == 32'h3FF, "R1 reset value", ctrl_reg, 32'h3FF);
    check(status_out == 0, "R1 status idle", status_out, 0);
    check({sdo_a, sdo_b, sdo_c} == 0, "R9 lanes low while idle", {sdo_a, sdo_b, sdo_c}, 0);
  endtask

  task automatic t_writes;
    write_ctrl(32, 64'h1C00_03FF);
    check(ctrl_reg == 32'h1C00_03FF, "R2 full write", ctrl_reg, 32'h1C00_03FF);
    write_ctrl(8, 64'hA5);
    check(ctrl_reg == 32'hA500_03FF, "R3 byte write", ctrl_reg, 32'hA500_03FF);
    write_ctrl(12, 64'h123);
    check(ctrl_reg == 32'hA500_03FF, "R4 12-bit frame ignored", ctrl_reg, 32'hA500_03FF);
    write_ctrl(33, 64'h0_0000_0000);
    check(ctrl_reg == 32'hA500_03FF, "R4 33-bit frame ignored", ctrl_reg, 32'hA500_03FF);
    write_ctrl(32, 64'h0000_03FF);
    check(ctrl_reg == 32'h3FF, "R2 restore", ctrl_reg, 32'h3FF);
  endtask

  task automatic t_conv_read;
    int cyc;
    logic [31:0] a, b, c;
    smp_a0 = 16'h8001; smp_a1 = 16'h1234; smp_b0 = 16'hBEEF;
    smp_b1 = 16'h00FF; smp_c0 = 16'h7F7F; smp_c1 = 16'hC003;
    pulse_measure(1'b1, 1'b0, cyc);
    check(cyc == LEN, "R5 internal length", cyc, LEN);
    smp_a0 = 16'h0; smp_b0 = 16'h0;
    do_frame(32, 64'h0000_03FF, a, b, c);
    check(a == 32'h8001_1234, "R8 lane A", a, 32'h8001_1234);
    check(b == 32'hBEEF_00FF, "R8 lane B", b, 32'hBEEF_00FF);
    check(c == 32'h7F7F_C003, "R7 lane C after completion", c, 32'h7F7F_C003);
    check({sdo_a, sdo_b, sdo_c} == 0, "R9 lanes low after frame", {sdo_a, sdo_b, sdo_c}, 0);
  endtask

  task automatic t_retrigger;
    int cyc;
    pulse_measure(1'b1, 1'b1, cyc);
    check(cyc == LEN, "R6 retrigger ignored", cyc, LEN);
  endtask

  task automatic t_ext_clock;
    int cyc;
    write_ctrl(32, 64'h0000_0BFF);
    ext_en = 1;
    pulse_measure(1'b1, 1'b0, cyc);
    ext_en = 0;
    check(cyc >= (LEN-1)*8 - 2 && cyc <= LEN*8 + 4, "R5 external time base", cyc, LEN*8);
    write_ctrl(32, 64'h0000_03FF);
  endtask

  task automatic t_polarity;
    int cyc;
    write_ctrl(32, 64'h0010_03FF);
    check(status_out == 1, "R10 busy low-active idle", status_out, 1);
    pulse_measure(1'b0, 1'b0, cyc);
    check(cyc == LEN, "R10 busy low-active length", cyc, LEN);
  endtask

  task automatic t_int_mode;
    write_ctrl(32, 64'h0020_03FF);
    check(status_out == 1, "R10 int idle", status_out, 1);
    @(negedge clk) conv_start = 1;
    repeat (4) @(negedge clk);
    conv_start = 0;
    repeat (6) @(negedge clk);
    check(status_out == 1, "R10 int inactive while converting", status_out, 1);
    repeat (40) @(negedge clk);
    check(status_out == 0, "R10 int asserted at completion", status_out, 0);
    write_ctrl(8, 64'h00);
    check(status_out == 1, "R10 int cleared by frame", status_out, 1);
  endtask

  task automatic t_reset_abort;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk) conv_start = 1;
    repeat (4) @(negedge clk);
    conv_start = 0;
    repeat (3) @(negedge clk);
    check(status_out == 1, "R6 busy during conversion", status_out, 1);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(status_out == 0, "R1 reset aborts", status_out, 0);
    check(ctrl_reg == 32'h3FF, "R1 reset reloads", ctrl_reg, 32'h3FF);
    repeat (60) @(negedge clk);
    check(status_out == 0, "R1 no late completion", status_out, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    t_reset();
    t_writes();
    t_conv_read();
    t_retrigger();
    t_ext_clock();
    t_polarity();
    t_int_mode();
    t_reset_abort();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule